// File: doc/BRIEF.md
# Card Clock Source Selector

This block produces the clock driven to a smart card and a companion clock output for the host. It chooses between three sources: an external strobe level, an internal RC oscillator and a crystal oscillator. It can also divide the selected source by two or four, or hold the card clock LOW. Everything runs on one fast system clock. Each oscillator arrives as a single-cycle tick enable, and the slow sleep-mode oscillator arrives as a separate tick input. Every tick flips the level of that oscillator, so an oscillator runs at half its tick rate. A card clock at ratio N toggles once every N ticks of its source.

The selection comes from four plain control pins: a run/sleep mode pin, a source-select pin and two divider-select pins. The source-select pin is sampled only while no card activation is in progress. A new selection takes effect only while the card clock is LOW. The divider counter restarts from zero on every change, so the card never sees a runt pulse or a shortened first LOW half-period. The block has no data stream, so it has no valid/ready interface.

Top module: `card_clk_sel`

## Requirements
- R1: With `run_mode`=1 and the sampled source select HIGH, `card_clk` equals `strobe_i` delayed by one system clock, and `comp_clk` is LOW.
- R2: With `run_mode`=1, source select LOW, `div_sel_a`=1 and `div_sel_b`=0, `card_clk` is the RC oscillator divided by 2 and `comp_clk` is the RC oscillator.
- R3: With `run_mode`=1, source select LOW, `div_sel_a`=0 and `div_sel_b`=0, `card_clk` is the crystal oscillator divided by 4 and `comp_clk` is the crystal oscillator.
- R4: With `run_mode`=1, source select LOW, `div_sel_a`=0 and `div_sel_b`=1, `card_clk` is the crystal oscillator divided by 2 and `comp_clk` is the crystal oscillator.
- R5: With `run_mode`=1, source select LOW, `div_sel_a`=1 and `div_sel_b`=1, `card_clk` stays LOW and `comp_clk` is the crystal oscillator.
- R6: With `run_mode`=0, `card_clk` stays LOW whatever the other selects are, and `comp_clk` is the slow oscillator.
- R7: While `act_busy` is HIGH, changes on `ext_src` are ignored. The last value sampled before `act_busy` rose stays in force, and a change is taken only once `act_busy` is LOW.
- R8: A change of source or divider is applied only while `card_clk` is LOW. A HIGH phase already in progress finishes at the old ratio, so no HIGH pulse is shorter than a normal half-period.
- R9: On any change of selection, including a restart from the stop-LOW state, the divider counter restarts at zero. The first rising edge of `card_clk` at ratio N therefore comes on the N-th source tick after the change.
- R10: During and right after reset, `card_clk` and `comp_clk` are LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | External strobe level, synchronous to clk |
| rc_tick | input | 1 | RC oscillator half-period tick |
| xtal_tick | input | 1 | Crystal oscillator half-period tick |
| slow_tick | input | 1 | Slow sleep-mode oscillator half-period tick |
| run_mode | input | 1 | 1 = normal operation, 0 = sleep |
| ext_src | input | 1 | 1 = card clock from strobe, 0 = internal oscillators |
| div_sel_a | input | 1 | First divider select |
| div_sel_b | input | 1 | Second divider select |
| act_busy | input | 1 | Card activation in progress; freezes the sampled source select |
| card_clk | output | 1 | Clock to the card |
| comp_clk | output | 1 | Companion clock output |

## Verification
A wrong divider count or a wrong decode shows up at the ports as a card or companion edge rate that is off the expected ratio. This becomes visible within one or two periods of the selected source. A selection register that updates while the card clock is HIGH shows up at once as a truncated HIGH pulse. A counter that is not cleared on a change shows up as a first rising edge after fewer than N ticks. A source select that leaks through while activation is busy switches the card clock to follow the strobe within two system clocks.

// File: rtl/card_clk_sel_pkg.sv
package card_clk_sel_pkg;
  typedef enum logic [2:0] {
    CFG_STROBE = 3'd0,
    CFG_RC_D2  = 3'd1,
    CFG_XT_D4  = 3'd2,
    CFG_XT_D2  = 3'd3,
    CFG_STOP   = 3'd4,
    CFG_SLEEP  = 3'd5
  } csel_cfg_e;

  localparam int NUM_SRC = 3;
  localparam int SRC_RC   = 0;
  localparam int SRC_XTAL = 1;
  localparam int SRC_SLOW = 2;
endpackage

// File: rtl/csel_decode.sv
module csel_decode
  import card_clk_sel_pkg::*;
(
  input  logic      run_mode,
  input  logic      src_ext,
  input  logic      div_a,
  input  logic      div_b,
  output csel_cfg_e cfg
);
  always_comb begin
    if (!run_mode)      cfg = CFG_SLEEP;
    else if (src_ext)   cfg = CFG_STROBE;
    else begin
      unique case ({div_a, div_b})
        2'b10:   cfg = CFG_RC_D2;
        2'b00:   cfg = CFG_XT_D4;
        2'b01:   cfg = CFG_XT_D2;
        default: cfg = CFG_STOP;
      endcase
    end
  end
endmodule

// File: rtl/csel_phase.sv
module csel_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= 1'b0;
    else if (tick) level <= ~level;
  end
endmodule

// File: rtl/csel_divider.sv
module csel_divider
  import card_clk_sel_pkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4,
  localparam int CW = $clog2(DIV_SLOW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  csel_cfg_e     cfg_q,
  input  logic          switching,
  input  logic          strobe_i,
  input  logic          rc_tick,
  input  logic          xtal_tick,
  output logic [CW-1:0] cnt,
  output logic          card_clk
);
  logic          tick_sel;
  logic [CW-1:0] limit;
  logic          dividing;

  always_comb begin
    dividing = 1'b1;
    tick_sel = xtal_tick;
    limit    = CW'(DIV_FAST);
    unique case (cfg_q)
      CFG_RC_D2: tick_sel = rc_tick;
      CFG_XT_D4: limit    = CW'(DIV_SLOW);
      CFG_XT_D2: ;
      default:   dividing = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (switching) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (cfg_q == CFG_STROBE) begin
      cnt      <= '0;
      card_clk <= strobe_i;
    end else if (!dividing) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (tick_sel) begin
      if (cnt == limit - CW'(1)) begin
        cnt      <= '0;
        card_clk <= ~card_clk;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
  import card_clk_sel_pkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4,
  localparam int CW = $clog2(DIV_SLOW) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic rc_tick,
  input  logic xtal_tick,
  input  logic slow_tick,
  input  logic run_mode,
  input  logic ext_src,
  input  logic div_sel_a,
  input  logic div_sel_b,
  input  logic act_busy,
  output logic card_clk,
  output logic comp_clk
);
  logic              src_q;
  csel_cfg_e         cfg_req;
  csel_cfg_e         cfg_q;
  logic              switching;
  logic [CW-1:0]     div_cnt;
  logic [NUM_SRC-1:0] ticks;
  logic [NUM_SRC-1:0] levels;

  // R7: source select frozen while activation busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         src_q <= 1'b0;
    else if (!act_busy) src_q <= ext_src;
  end

  csel_decode u_dec (
    .run_mode (run_mode),
    .src_ext  (src_q),
    .div_a    (div_sel_a),
    .div_b    (div_sel_b),
    .cfg      (cfg_req)
  );

  // R8: selection applied only while card clock is LOW
  assign switching = (cfg_req != cfg_q) && !card_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= CFG_STOP;
    else if (switching) cfg_q <= cfg_req;
  end

  assign ticks[SRC_RC]   = rc_tick;
  assign ticks[SRC_XTAL] = xtal_tick;
  assign ticks[SRC_SLOW] = slow_tick;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_phase
    csel_phase u_ph (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ticks[i]),
      .level (levels[i])
    );
  end

  csel_divider #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_q     (cfg_q),
    .switching (switching),
    .strobe_i  (strobe_i),
    .rc_tick   (rc_tick),
    .xtal_tick (xtal_tick),
    .cnt       (div_cnt),
    .card_clk  (card_clk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comp_clk <= 1'b0;
    else begin
      unique case (cfg_q)
        CFG_STROBE: comp_clk <= 1'b0;
        CFG_RC_D2:  comp_clk <= levels[SRC_RC];
        CFG_SLEEP:  comp_clk <= levels[SRC_SLOW];
        default:    comp_clk <= levels[SRC_XTAL];
      endcase
    end
  end
endmodule

// File: rtl/card_clk_sel_chk.sv
module card_clk_sel_chk
  import card_clk_sel_pkg::*;
#(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_i,
  input logic          act_busy,
  input logic          card_clk,
  input logic          comp_clk,
  input csel_cfg_e     cfg_q,
  input logic          src_q,
  input logic [CW-1:0] div_cnt
);
  a_r1_strobe_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_STROBE && $past(cfg_q) == CFG_STROBE) |-> card_clk == $past(strobe_i));

  a_r1_comp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_STROBE && $past(cfg_q) == CFG_STROBE) |-> !comp_clk);

  a_r5_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_STOP || cfg_q == CFG_SLEEP) |-> !card_clk);

  a_r7_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    act_busy |=> src_q == $past(src_q));

  a_r8_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> (!$past(card_clk) && !card_clk));

  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> div_cnt == '0);

  always_comb begin
    if (!rst_n) a_r10_reset_low: assert (!card_clk && !comp_clk);
  end
endmodule

bind card_clk_sel card_clk_sel_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe_i (strobe_i),
  .act_busy (act_busy),
  .card_clk (card_clk),
  .comp_clk (comp_clk),
  .cfg_q    (cfg_q),
  .src_q    (src_q),
  .div_cnt  (div_cnt)
);

// File: tb/card_clk_sel_test.sv
module card_clk_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_i = 1'b0;
  logic rc_tick = 1'b0, xtal_tick = 1'b0, slow_tick = 1'b0;
  logic run_mode = 1'b1, ext_src = 1'b0, div_sel_a = 1'b0, div_sel_b = 1'b1;
  logic act_busy = 1'b0;
  logic card_clk, comp_clk;

  int errors = 0, checks = 0;
  logic xt_en = 1'b1;
  int xt_pulses = 0;
  int gcnt = 0;
  bit done = 0;

  card_clk_sel uut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i),
    .rc_tick(rc_tick), .xtal_tick(xtal_tick), .slow_tick(slow_tick),
    .run_mode(run_mode), .ext_src(ext_src), .div_sel_a(div_sel_a),
    .div_sel_b(div_sel_b), .act_busy(act_busy),
    .card_clk(card_clk), .comp_clk(comp_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick sources: rc every 3 cycles, xtal every 2, slow every 8
  always @(negedge clk) begin
    gcnt++;
    rc_tick   <= (gcnt % 3 == 0);
    slow_tick <= (gcnt % 8 == 0);
    if (xt_en && (gcnt % 2 == 0)) begin
      xtal_tick <= 1'b1;
      xt_pulses <= xt_pulses + 1;
    end else begin
      xtal_tick <= 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp_lo, input int exp_hi);
    checks++;
    if (act < exp_lo || act > exp_hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic set_cfg(input logic rm, input logic es, input logic a, input logic b);
    @(negedge clk);
    run_mode = rm; ext_src = es; div_sel_a = a; div_sel_b = b;
    repeat (40) @(posedge clk);
  endtask

  task automatic measure(output int card_r, output int comp_r);
    logic pc, pk;
    card_r = 0; comp_r = 0;
    @(posedge clk); #1;
    pc = card_clk; pk = comp_clk;
    for (int i = 0; i < WIN; i++) begin
      @(posedge clk); #1;
      if (card_clk && !pc) card_r++;
      if (comp_clk && !pk) comp_r++;
      pc = card_clk; pk = comp_clk;
    end
  endtask

  task automatic t_reset;
    #1;
    check("R10 card in reset", card_clk, 0, 0);
    check("R10 comp in reset", comp_clk, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 card after reset", card_clk, 0, 0);
  endtask

  task automatic t_rates(input logic rm, input logic es, input logic a, input logic b,
                         input string req, input int card_exp, input int comp_exp);
    int cr, kr;
    set_cfg(rm, es, a, b);
    measure(cr, kr);
    check({req, " card rate"}, cr, card_exp - 1, card_exp + 1);
    check({req, " comp rate"}, kr, comp_exp - 1, comp_exp + 1);
  endtask

  task automatic t_strobe;
    logic [15:0] pat = 16'b1100_1011_0111_0010;
    int bad = 0, kr = 0;
    set_cfg(1, 1, 0, 1);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk); strobe_i = pat[i % 16];
      @(posedge clk); #1;
      if (card_clk !== pat[i % 16]) bad++;
      if (comp_clk) kr++;
    end
    check("R1 card follows strobe (mismatches)", bad, 0, 0);
    check("R1 comp held LOW (high samples)", kr, 0, 0);
    @(negedge clk); strobe_i = 1'b0;
  endtask

  task automatic t_busy;
    int cr, kr;
    set_cfg(1, 0, 0, 1);
    @(negedge clk); act_busy = 1'b1;
    @(negedge clk); ext_src = 1'b1;
    repeat (20) @(posedge clk);
    measure(cr, kr);
    check("R7 card while busy", cr, 29, 31);
    check("R7 comp while busy", kr, 59, 61);
    @(negedge clk); act_busy = 1'b0;
    repeat (40) @(posedge clk);
    measure(cr, kr);
    check("R7 strobe taken after busy (comp)", kr, 0, 0);
    check("R7 strobe taken after busy (card low)", cr, 0, 0);
    @(negedge clk); ext_src = 1'b0;
  endtask

  task automatic t_no_runt;
    int minh = 1000, h = 0, nh = 0;
    logic pc;
    set_cfg(1, 0, 0, 0);
    do begin @(posedge clk); #1; end while (!card_clk);
    @(negedge clk); div_sel_b = 1'b1;
    pc = 1'b1; h = 1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (card_clk) h++;
      else if (pc) begin
        nh++;
        if (h < minh) minh = h;
        h = 0;
      end
      pc = card_clk;
    end
    check("R8 pulses seen", nh, 5, 100);
    check("R8 min HIGH width", minh, 4, 1000);
  endtask

  task automatic t_restart(input logic b, input int n, input string req);
    int start;
    set_cfg(1, 0, 1, 1);
    @(negedge clk); xt_en = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); div_sel_a = 1'b0; div_sel_b = b;
    repeat (5) @(posedge clk);
    #1;
    check({req, " card LOW before ticks"}, card_clk, 0, 0);
    @(negedge clk); start = xt_pulses; xt_en = 1'b1;
    do begin @(posedge clk); #1; end while (!card_clk);
    check({req, " ticks to first rise"}, xt_pulses - start, n, n);
  endtask

  initial begin
    t_reset();
    t_rates(1, 0, 1, 0, "R2 rc/2", 20, 40);
    t_rates(1, 0, 0, 0, "R3 xtal/4", 15, 60);
    t_rates(1, 0, 0, 1, "R4 xtal/2", 30, 60);
    t_rates(1, 0, 1, 1, "R5 stop", 0, 60);
    t_rates(0, 0, 0, 1, "R6 sleep xt2 sel", 0, 15);
    t_rates(0, 1, 1, 0, "R6 sleep strobe sel", 0, 15);
    t_strobe();
    t_busy();
    t_no_runt();
    t_restart(1, 2, "R9 restart /2");
    t_restart(0, 4, "R9 restart /4");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule